// File: doc/BRIEF.md
# Oversampled Voting Bit Sampler

This block turns a serial line, sampled at eight times the bit rate, into one decoded bit per bit period. The raw samples first pass through a sliding five-sample majority vote. The registered vote drives both the falling-edge detector and the bit capture. A phase counter runs modulo eight and selects one position near the middle of each bit window. At that position the voted level is latched and a one-cycle strobe is raised.

The framing logic above this block drives a resync-enable input. It holds this input high while the receiver is idle or expects the first bit of a byte start sequence. Only while it is high does a voted high-to-low transition realign the phase counter. Edges inside a byte therefore never disturb the bit timing. Between realignments the counter free-runs. The line idles high, and reset loads the vote history with ones, so releasing reset never produces a false edge.

Top module: `ovs_bit_sampler`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `voted_o` is 1 and `bit_stb_o` is 0. While the line stays high after reset, `voted_o` stays 1.
- R2: After each rising clock edge, `voted_o` equals the majority of the five most recent raw line samples, including the sample taken at that edge. It is 0 when at least three of those samples are 0.
- R3: Whenever `bit_stb_o` is 1, `bit_o` holds the value `voted_o` had in the preceding cycle. `bit_o` keeps its value between strobes.
- R4: When no qualifying falling edge occurs, `bit_stb_o` is high for exactly one cycle in every eight, at a fixed phase.
- R5: A falling edge of `voted_o` while `resync_en_i` is 0 does not move the strobe phase.
- R6: Suppose `voted_o` falls after clock edge e and `resync_en_i` is 1 at edge e+1. Then `bit_stb_o` is high after edge e+5 and every eighth edge after that. For a clean step, this puts the strobe in the cycle after the eighth edge that samples the new low level, with the bit value taken from raw samples 2 to 6 of the 0-to-7 bit window.
- R7: A single raw sample that disagrees with its neighbours never changes `voted_o`. A disagreeing sample at position 0 or 7 of a bit window never changes that bit's captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, eight cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw serial line sample |
| resync_en_i | input | 1 | Allows a voted falling edge to realign the bit phase |
| voted_o | output | 1 | Registered majority-voted line |
| bit_stb_o | output | 1 | One-cycle strobe per decoded bit |
| bit_o | output | 1 | Decoded bit value, valid with the strobe |

## Verification
The assertions check four things on every cycle. A change of the voted line must agree with the newest raw sample. The phase count stays in range and reloads to its fixed value on a qualifying edge. A gated edge leaves the count stepping as before. Each strobe carries the previous voted level and never repeats in the next cycle. The exact strobe placement relative to a frame's start edge, the recovery of whole bit sequences with boundary glitches, and the fixed strobe phase across a gated edge depend on multi-bit histories, so only the bench scenarios show them.

// File: rtl/ovs_sampler_pkg.sv
package ovs_sampler_pkg;
   localparam int unsigned DEF_OVERSAMPLE   = 8;
   localparam int unsigned DEF_VOTE_DEPTH   = 5;
   localparam int unsigned DEF_SAMPLE_POINT = 4;
   // value the phase counter takes in the cycle after a qualifying edge
   localparam int unsigned RESYNC_LOAD      = 1;
endpackage

// File: rtl/ovs_vote_filter.sv
module ovs_vote_filter #(
   parameter int unsigned DEPTH = ovs_sampler_pkg::DEF_VOTE_DEPTH
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic vote_o
);
   localparam int unsigned HALF = DEPTH / 2;

   if ((DEPTH % 2) == 0) begin : g_bad_depth
      $error("ovs_vote_filter: DEPTH must be odd");
   end

   logic vote_q;

   if (DEPTH == 1) begin : g_pass
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) vote_q <= 1'b1;
         else         vote_q <= raw_i;
      end
   end else begin : g_vote
      logic [DEPTH-2:0] hist_q;
      logic [DEPTH-1:0] window_w;
      assign window_w = {hist_q, raw_i};
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hist_q <= '1;
            vote_q <= 1'b1;
         end else begin
            hist_q <= window_w[DEPTH-2:0];
            vote_q <= ($countones(window_w) > HALF);
         end
      end
   end

   assign vote_o = vote_q;

   AST_VOTE_FOLLOWS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vote_o != $past(vote_o)) |-> ($past(raw_i) == vote_o)); // R2
endmodule

// File: rtl/ovs_phase_ctr.sv
module ovs_phase_ctr #(
   parameter int unsigned OVERSAMPLE   = ovs_sampler_pkg::DEF_OVERSAMPLE,
   parameter int unsigned SAMPLE_POINT = ovs_sampler_pkg::DEF_SAMPLE_POINT
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic vote_i,
   input  logic resync_en_i,
   output logic take_o
);
   import ovs_sampler_pkg::*;
   localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESYNC_LOAD);
   localparam logic [CNT_W-1:0] CNT_TAKE = CNT_W'(SAMPLE_POINT);

   if (OVERSAMPLE < 4) begin : g_bad_os
      $error("ovs_phase_ctr: OVERSAMPLE must be at least 4");
   end
   if ((SAMPLE_POINT >= OVERSAMPLE) || (SAMPLE_POINT < RESYNC_LOAD)) begin : g_bad_sp
      $error("ovs_phase_ctr: SAMPLE_POINT out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             vote_prev_q;
   logic             fall_w;

   assign fall_w = vote_prev_q & ~vote_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q       <= '0;
         vote_prev_q <= 1'b1;
      end else begin
         vote_prev_q <= vote_i;
         if (fall_w && resync_en_i) cnt_q <= CNT_LOAD;
         else if (cnt_q == CNT_LAST) cnt_q <= '0;
         else                        cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign take_o = (cnt_q == CNT_TAKE);

   AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_LAST); // R4
   AST_RESYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_w && resync_en_i) |=> (cnt_q == CNT_LOAD)); // R6
   AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_w && !resync_en_i) |=>
         (cnt_q == (($past(cnt_q) == CNT_LAST) ? '0 : $past(cnt_q) + CNT_W'(1)))); // R5
endmodule

// File: rtl/ovs_bit_capture.sv
module ovs_bit_capture (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic take_i,
   input  logic vote_i,
   output logic stb_o,
   output logic bit_o
);
   logic stb_q;
   logic bit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stb_q <= 1'b0;
         bit_q <= 1'b1;
      end else begin
         stb_q <= take_i;
         if (take_i) bit_q <= vote_i;
      end
   end

   assign stb_o = stb_q;
   assign bit_o = bit_q;

   AST_BIT_FROM_VOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o |-> (bit_o == $past(vote_i))); // R3
   AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o |=> !stb_o); // R4
endmodule

// File: rtl/ovs_bit_sampler.sv
module ovs_bit_sampler #(
   parameter int unsigned OVERSAMPLE   = ovs_sampler_pkg::DEF_OVERSAMPLE,
   parameter int unsigned VOTE_DEPTH   = ovs_sampler_pkg::DEF_VOTE_DEPTH,
   parameter int unsigned SAMPLE_POINT = ovs_sampler_pkg::DEF_SAMPLE_POINT
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic resync_en_i,
   output logic voted_o,
   output logic bit_stb_o,
   output logic bit_o
);
   logic vote_w;
   logic take_w;

   ovs_vote_filter #(.DEPTH(VOTE_DEPTH)) vote_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (line_i),
      .vote_o (vote_w)
   );

   ovs_phase_ctr #(.OVERSAMPLE(OVERSAMPLE), .SAMPLE_POINT(SAMPLE_POINT)) phase_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .vote_i      (vote_w),
      .resync_en_i (resync_en_i),
      .take_o      (take_w)
   );

   ovs_bit_capture cap_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take_w),
      .vote_i (vote_w),
      .stb_o  (bit_stb_o),
      .bit_o  (bit_o)
   );

   assign voted_o = vote_w;

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (voted_o && !bit_stb_o)); // R1
endmodule

// File: tb/ovs_bit_sampler_tb.sv
module ovs_bit_sampler_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line = 1'b1;
   logic en = 1'b0;
   logic voted, stb, bitv;

   int n_tests = 0;
   int n_fail = 0;
   int ncyc = 0;
   bit done = 1'b0;

   // reference state after the latest rising edge
   logic [3:0] m_hist;
   logic m_v, m_vp, m_stb, m_bit;
   int m_cnt;

   // directed-window bookkeeping
   int win_lo = -1, win_hi = -2, win_t0 = 0;
   logic exp_bits [0:15];
   bit phase_watch = 1'b0;
   int phase_ref = 0;
   int phase_hits = 0;
   int last_stb = -1;

   always #5 clk = ~clk;

   ovs_bit_sampler dut_i (
      .clk_i(clk), .rst_ni(rst_n), .line_i(line), .resync_en_i(en),
      .voted_o(voted), .bit_stb_o(stb), .bit_o(bitv)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, ncyc, act, exp);
      end
   endtask

   function automatic logic maj5(input logic [3:0] h, input logic r);
      int zeros = 0;
      for (int i = 0; i < 4; i++) if (!h[i]) zeros++;
      if (!r) zeros++;
      return (zeros >= 3) ? 1'b0 : 1'b1;
   endfunction

   task automatic model_step();
      logic nv, nstb, nbit, fall;
      int ncnt;
      if (!rst_n) begin
         m_hist = 4'hF; m_v = 1'b1; m_vp = 1'b1; m_stb = 1'b0; m_bit = 1'b1; m_cnt = 0;
      end else begin
         nstb = (m_cnt == 4);
         nbit = nstb ? m_v : m_bit;
         fall = m_vp & ~m_v;
         ncnt = (fall && en) ? 1 : (m_cnt + 1) % 8;
         nv   = maj5(m_hist, line);
         m_vp = m_v; m_v = nv; m_stb = nstb; m_bit = nbit; m_cnt = ncnt;
         m_hist = {m_hist[2:0], line};
      end
   endtask

   // one clock: inputs held across the edge, outputs checked at the falling edge
   task automatic cyc(input logic r, input logic e);
      line = r; en = e;
      @(posedge clk);
      @(negedge clk);
      ncyc++;
      model_step();
      check(voted === m_v, "R2 voted", voted, m_v);
      check(stb === m_stb, "R4 strobe", stb, m_stb);
      if (m_stb) check(bitv === m_bit, "R3 bit", bitv, m_bit);
      if (ncyc >= win_lo && ncyc <= win_hi) begin
         if (((ncyc - win_lo) % 8) == 0) begin
            check(stb === 1'b1, "R6 strobe placement", stb, 1);
            check(bitv === exp_bits[(ncyc - win_lo) / 8], "R7 bit with boundary glitch",
                  bitv, exp_bits[(ncyc - win_lo) / 8]);
         end else begin
            check(stb === 1'b0, "R6 no extra strobe", stb, 0);
         end
      end
      if (phase_watch && stb) begin
         phase_hits++;
         check(((ncyc - phase_ref) % 8) == 0, "R5 phase kept", (ncyc - phase_ref) % 8, 0);
      end
      if (stb) last_stb = ncyc;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic r;
      void'($urandom(32'd2024));
      // reset
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 1'b1);
         check(voted === 1'b1, "R1 voted in reset", voted, 1);
         check(stb === 1'b0, "R1 strobe in reset", stb, 0);
      end
      rst_n = 1'b1;
      cyc(1'b1, 1'b1);
      check(voted === 1'b1 && stb === 1'b0, "R1 after release", {voted, stb}, 2);
      for (int i = 0; i < 20; i++) begin
         cyc(1'b1, 1'b1);
         check(voted === 1'b1, "R1 idle high", voted, 1);
      end
      // single glitch in idle
      cyc(1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         cyc(1'b1, 1'b1);
         check(voted === 1'b1, "R7 idle glitch", voted, 1);
      end
      // directed frame with boundary glitches
      exp_bits[0] = 1'b0;
      for (int i = 1; i < 12; i++) exp_bits[i] = 1'($urandom % 2);
      win_t0 = ncyc + 1;
      win_lo = win_t0 + 7;
      win_hi = win_lo + 8 * 11;
      for (int i = 0; i < 12; i++) begin
         for (int s = 0; s < 8; s++) begin
            r = exp_bits[i];
            if (i > 0 && (s == 0 || s == 7) && ($urandom % 2 == 1)) r = ~r;
            cyc(r, (i == 0) ? 1'b1 : 1'b0);
         end
      end
      for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0);
      win_lo = -1; win_hi = -2;
      // gated falling edge keeps the phase
      phase_ref = last_stb;
      phase_watch = 1'b1;
      phase_hits = 0;
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
      for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0);
      for (int i = 0; i < 24; i++) cyc(1'b1, 1'b0);
      phase_watch = 1'b0;
      check(phase_hits == 4 || phase_hits == 5, "R4 strobes per window", phase_hits, 4);
      // random traffic
      for (int b = 0; b < 500; b++) begin
         logic bv;
         bv = 1'($urandom % 2);
         for (int s = 0; s < 8; s++) begin
            r = bv;
            if ($urandom % 16 == 0) r = ~r;
            cyc(r, ($urandom % 4 == 0) ? 1'b1 : 1'b0);
         end
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule